// File: doc/BRIEF.md
# Status register transfer unit

This block keeps the processor's live status word and one saved status word belonging to the active exception mode. It serves the two status-move operations of a core. A read copies either word onto a registered read port. A write replaces chosen bytes of either word under a four-bit byte-enable mask. The write operand is either a full register value or an 8-bit constant rotated right by an even amount.

Protection follows the mode field held in the low five bits of the live word. Mode 0x10 is the only unprivileged mode. In it, only the top byte of the live word can change, and that byte holds the condition flags N, Z, C and V at bits 31 down to 28. The saved word exists only in modes other than 0x10 and 0x1F. In those two modes, writes to it are dropped. Reads of it return zero and raise a one-cycle error pulse. When the condition-passed input is low, an access does nothing.

Top module: `psr_xfer`

## Requirements
- R1: The write operand is `regOperand` when `useImm` is 0. When `useImm` is 1, it is `immByte`, zero-extended to 32 bits and rotated right by 2×`rotAmt` bits.
- R2: Mask bit 3 enables byte [31:24], bit 2 enables [23:16], bit 1 enables [15:8] and bit 0 enables [7:0]. Disabled bytes keep their value, and a mask of 0 changes nothing.
- R3: A write to the live word (`selSaved`=0) updates bytes [23:0] only when the mode field [4:0] is not 0x10. Byte [31:24] is updated in any mode. A privileged write of 0x13 into bits [4:0] selects mode 0x13.
- R4: A write to the saved word (`selSaved`=1) updates its enabled bytes only when the mode is neither 0x10 nor 0x1F.
- R5: A read (`isWrite`=0) loads `rdData` on the following clock edge. It loads the saved word when `selSaved`=1 and the live word when `selSaved`=0, and it leaves both words unchanged.
- R6: A read of the saved word in mode 0x10 or 0x1F returns zero on `rdData`, and `rdErr` is high for exactly the cycle after that access. `rdErr` is low at all other times.
- R7: After reset, `curStatus` is 0x00000013 (mode 0x13, flags clear), the saved word is 0, `rdData` is 0 and `rdErr` is 0.
- R8: An access with `condPass` low changes neither word, `rdData` nor `rdErr`.
- R9: Privilege and saved-word presence are judged from the mode held before an access. A write that changes the mode takes effect for the next access only.

Byte-enable masks and the mode field above are used exactly as stated. All updates appear on `curStatus` and `rdData` one clock edge after the access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| isWrite | input | 1 | 1 for a write, 0 for a read |
| selSaved | input | 1 | 1 targets the saved word, 0 the live word |
| fieldMask | input | 4 | Byte-enable mask for writes |
| useImm | input | 1 | Select the rotated constant as operand |
| immByte | input | 8 | 8-bit constant |
| rotAmt | input | 4 | Rotation count in units of two bits |
| regOperand | input | 32 | Register operand |
| condPass | input | 1 | Condition passed; low cancels the access |
| curStatus | output | 32 | Live status word |
| rdData | output | 32 | Registered read result |
| rdErr | output | 1 | One-cycle pulse on a saved-word read without a saved word |

## Verification
Every one of the sixteen mask values is written in three modes, 0x13, 0x1F and 0x10. Each operand carries a distinct value per byte, so a wrong byte lane or a missing protection bit shows up as a wrong byte. Mode 0x13 separates live-word writes from saved-word writes. Mode 0x1F keeps live-word privilege but removes the saved word, and mode 0x10 removes both. Rotated constants with counts of 0, 4 and 15 distinguish rotate direction and the doubling of the count. Cancelled accesses and a write that drops into mode 0x10 test R8 and R9.

// File: rtl/psr_xfer_pkg.sv
package psr_xfer_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_N = DATA_W / 8;
  localparam int MODE_W = 5;
  localparam int ROT_W  = 4;
  localparam int IMM_W  = 8;

  localparam logic [MODE_W-1:0] MODE_USER = 5'h10;
  localparam logic [MODE_W-1:0] MODE_SYST = 5'h1F;
  localparam logic [MODE_W-1:0] MODE_SUPV = 5'h13;

  typedef struct packed {
    logic [BYTE_N-1:0] curWe;
    logic [BYTE_N-1:0] savWe;
    logic              rdLoad;
    logic              rdSaved;
    logic              rdBlock;
  } strobe_t;
endpackage

// File: rtl/psr_xfer_ctrl.sv
module psr_xfer_ctrl
  import psr_xfer_pkg::*;
(
  input  logic              accValid,
  input  logic              isWrite,
  input  logic              selSaved,
  input  logic              condPass,
  input  logic [BYTE_N-1:0] fieldMask,
  input  logic [MODE_W-1:0] curMode,
  output strobe_t           stb
);
  logic privileged;
  logic hasSaved;
  logic go;
  logic [BYTE_N-1:0] curWe;
  logic [BYTE_N-1:0] savWe;

  always_comb begin
    privileged = (curMode != MODE_USER);
    hasSaved   = privileged && (curMode != MODE_SYST);
    go         = accValid && condPass;
  end

  for (genvar b = 0; b < BYTE_N; b++) begin : g_lane
    localparam bit TOP_LANE = (b == BYTE_N - 1);
    assign curWe[b] = go && isWrite && !selSaved && fieldMask[b] && (TOP_LANE || privileged);
    assign savWe[b] = go && isWrite && selSaved && fieldMask[b] && hasSaved;
  end

  assign stb = '{curWe:   curWe,
                 savWe:   savWe,
                 rdLoad:  go && !isWrite,
                 rdSaved: selSaved,
                 rdBlock: selSaved && !hasSaved};
endmodule

// File: rtl/psr_xfer_dp.sv
module psr_xfer_dp
  import psr_xfer_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_CUR = 32'h0000_0013
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immByte,
  input  logic [ROT_W-1:0]  rotAmt,
  input  logic [DATA_W-1:0] regOperand,
  output logic [DATA_W-1:0] curStatus,
  output logic [MODE_W-1:0] curMode,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr
);
  logic [DATA_W-1:0]   curReg;
  logic [DATA_W-1:0]   savReg;
  logic [DATA_W-1:0]   immWide;
  logic [2*DATA_W-1:0] rotPair;
  logic [DATA_W-1:0]   operand;

  always_comb begin
    immWide = {{(DATA_W-IMM_W){1'b0}}, immByte};
    rotPair = {immWide, immWide} >> {rotAmt, 1'b0};
    operand = useImm ? rotPair[DATA_W-1:0] : regOperand;
  end

  for (genvar b = 0; b < BYTE_N; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        curReg[b*8 +: 8] <= RESET_CUR[b*8 +: 8];
        savReg[b*8 +: 8] <= '0;
      end else begin
        if (stb.curWe[b]) curReg[b*8 +: 8] <= operand[b*8 +: 8];
        if (stb.savWe[b]) savReg[b*8 +: 8] <= operand[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      rdErr  <= 1'b0;
    end else begin
      rdErr <= stb.rdLoad && stb.rdSaved && stb.rdBlock;
      if (stb.rdLoad) begin
        if (!stb.rdSaved)     rdData <= curReg;
        else if (stb.rdBlock) rdData <= '0;
        else                  rdData <= savReg;
      end
    end
  end

  assign curStatus = curReg;
  assign curMode   = curReg[MODE_W-1:0];
endmodule

// File: rtl/psr_xfer.sv
module psr_xfer
  import psr_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              isWrite,
  input  logic              selSaved,
  input  logic [BYTE_N-1:0] fieldMask,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immByte,
  input  logic [ROT_W-1:0]  rotAmt,
  input  logic [DATA_W-1:0] regOperand,
  input  logic              condPass,
  output logic [DATA_W-1:0] curStatus,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr
);
  strobe_t           stb;
  logic [MODE_W-1:0] curMode;

  psr_xfer_ctrl u_ctrl (
    .accValid (accValid),
    .isWrite  (isWrite),
    .selSaved (selSaved),
    .condPass (condPass),
    .fieldMask(fieldMask),
    .curMode  (curMode),
    .stb      (stb)
  );

  psr_xfer_dp #(.RESET_CUR({{(DATA_W-MODE_W){1'b0}}, MODE_SUPV})) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .useImm    (useImm),
    .immByte   (immByte),
    .rotAmt    (rotAmt),
    .regOperand(regOperand),
    .curStatus (curStatus),
    .curMode   (curMode),
    .rdData    (rdData),
    .rdErr     (rdErr)
  );
endmodule

// File: rtl/psr_xfer_chk.sv
module psr_xfer_chk
  import psr_xfer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              isWrite,
  input logic              selSaved,
  input logic [BYTE_N-1:0] fieldMask,
  input logic              condPass,
  input logic [DATA_W-1:0] curStatus,
  input logic [DATA_W-1:0] rdData,
  input logic              rdErr
);
  p_user_low_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (curStatus[MODE_W-1:0] == MODE_USER) |=> $stable(curStatus[23:0]));

  p_zero_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && isWrite && fieldMask == '0) |=> $stable(curStatus));

  p_top_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && isWrite && !selSaved && !fieldMask[BYTE_N-1]) |=> $stable(curStatus[DATA_W-1:DATA_W-8]));

  p_read_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !isWrite) |=> $stable(curStatus));

  p_no_saved_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && condPass && !isWrite && selSaved &&
     (curStatus[MODE_W-1:0] == MODE_USER || curStatus[MODE_W-1:0] == MODE_SYST))
    |=> (rdErr && rdData == '0));

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> $past(accValid && condPass && !isWrite && selSaved));

  p_cancel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!condPass) |=> (!rdErr && $stable(curStatus) && $stable(rdData)));
endmodule

bind psr_xfer psr_xfer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .isWrite  (isWrite),
  .selSaved (selSaved),
  .fieldMask(fieldMask),
  .condPass (condPass),
  .curStatus(curStatus),
  .rdData   (rdData),
  .rdErr    (rdErr)
);

// File: tb/psr_xfer_tb.sv
`timescale 1ns/1ps
module psr_xfer_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid, isWrite, selSaved, useImm, condPass;
  logic [3:0]  fieldMask, rotAmt;
  logic [7:0]  immByte;
  logic [31:0] regOperand;
  logic [31:0] curStatus, rdData;
  logic        rdErr;

  always #2 clk = ~clk;

  psr_xfer u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .isWrite(isWrite),
    .selSaved(selSaved), .fieldMask(fieldMask), .useImm(useImm),
    .immByte(immByte), .rotAmt(rotAmt), .regOperand(regOperand),
    .condPass(condPass), .curStatus(curStatus), .rdData(rdData), .rdErr(rdErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic [31:0] mCur, mSav, mRd;
  logic        mErr;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit noSaved(logic [31:0] w);
    return (w[4:0] == 5'h10) || (w[4:0] == 5'h1F);
  endfunction

  task automatic op(string tag, bit v, bit w, bit s, logic [3:0] m, bit imm,
                    logic [7:0] ib, logic [3:0] ra, logic [31:0] rv, bit cp);
    logic [31:0] opnd, nCur, nSav;
    accValid = v; isWrite = w; selSaved = s; fieldMask = m; useImm = imm;
    immByte = ib; rotAmt = ra; regOperand = rv; condPass = cp;
    if (imm) begin
      opnd = {24'b0, ib};
      for (int k = 0; k < 2 * int'(ra); k++) opnd = {opnd[0], opnd[31:1]};
    end else opnd = rv;
    nCur = mCur; nSav = mSav; mErr = 1'b0;
    if (v && cp) begin
      if (w) begin
        for (int b = 0; b < 4; b++) begin
          if (m[b] && !s && (b == 3 || mCur[4:0] != 5'h10)) nCur[b*8 +: 8] = opnd[b*8 +: 8];
          if (m[b] && s && !noSaved(mCur))                  nSav[b*8 +: 8] = opnd[b*8 +: 8];
        end
      end else if (s) begin
        if (noSaved(mCur)) begin mRd = 32'h0; mErr = 1'b1; end
        else mRd = mSav;
      end else mRd = mCur;
    end
    mCur = nCur; mSav = nSav;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " curStatus"}, curStatus, mCur);
    chk({tag, " rdData"}, rdData, mRd);
    chk({tag, " rdErr"}, {31'b0, rdErr}, {31'b0, mErr});
  endtask

  task automatic wr(string tag, bit s, logic [3:0] m, logic [31:0] val);
    op(tag, 1, 1, s, m, 0, 8'h0, 4'h0, val, 1);
  endtask

  task automatic rd(string tag, bit s);
    op(tag, 1, 0, s, 4'h0, 0, 8'h0, 4'h0, 32'h0, 1);
  endtask

  function automatic logic [31:0] pat(logic [3:0] m, logic [7:0] low);
    return {m, 4'h5, 8'h3C ^ {m, m}, 8'h96 ^ {m, 4'h0}, low};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; accValid = 0; isWrite = 0; selSaved = 0; fieldMask = 0;
    useImm = 0; immByte = 0; rotAmt = 0; regOperand = 0; condPass = 1;
    mCur = 32'h0000_0013; mSav = 32'h0; mRd = 32'h0; mErr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R7 reset curStatus", curStatus, 32'h0000_0013);
    chk("R7 reset rdData", rdData, 32'h0);
    chk("R7 reset rdErr", {31'b0, rdErr}, 32'h0);
    rd("R7 R5 reset saved read", 1);
    rd("R5 live read", 0);

    for (int m = 0; m < 16; m++) begin
      wr("R2 R3 supv live", 0, 4'(m), pat(4'(m), 8'hD3));
      wr("R4 supv saved", 1, 4'(m), ~pat(4'(m), 8'h2C));
      rd("R5 supv saved read", 1);
      rd("R5 supv live read", 0);
    end
    op("R2 idle", 0, 1, 0, 4'hF, 0, 8'h0, 4'h0, 32'hFFFF_FFFF, 1);

    wr("R3 enter sys", 0, 4'b0001, 32'h0000_001F);
    for (int m = 0; m < 16; m++) begin
      wr("R3 sys live", 0, 4'(m), pat(4'(m), 8'h5F));
      wr("R4 sys saved dropped", 1, 4'(m), 32'hDEAD_BEEF);
      rd("R6 sys saved read", 1);
      rd("R5 sys live read", 0);
    end

    op("R1 imm rot4", 1, 1, 0, 4'b1000, 1, 8'hF0, 4'd4, 32'h0, 1);
    op("R1 imm rot0", 1, 1, 0, 4'b0010, 1, 8'hA5, 4'd0, 32'h0, 1);
    op("R1 imm rot15", 1, 1, 0, 4'b0110, 1, 8'h81, 4'd15, 32'h0, 1);
    op("R1 reg operand", 1, 1, 0, 4'b0100, 0, 8'hFF, 4'd3, 32'h0077_0000, 1);

    rd("R8 prime read", 0);
    op("R8 cancelled write", 1, 1, 0, 4'hF, 0, 8'h0, 4'h0, 32'h0, 0);
    op("R8 cancelled saved read", 1, 0, 1, 4'h0, 0, 8'h0, 4'h0, 32'h0, 0);

    wr("R9 drop to user", 0, 4'b0011, 32'h0000_AA10);
    wr("R9 R3 user low byte ignored", 0, 4'b0001, 32'h0000_0013);
    wr("R3 user mask1000 top only", 0, 4'b1000, 32'h9ABC_DE13);
    for (int m = 0; m < 16; m++) begin
      wr("R3 user live", 0, 4'(m), pat(4'(m), 8'h13));
      wr("R4 user saved dropped", 1, 4'(m), 32'h1234_5678);
      rd("R6 user saved read", 1);
      rd("R5 user live read", 0);
    end
    op("R6 no lingering err", 0, 0, 0, 4'h0, 0, 8'h0, 4'h0, 32'h0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule